// File: doc/BRIEF.md
# Processor bus cycle sequencer

This block is the bus-master side of a processor's external bus. For each accepted request it runs one access: one address cycle, then one to four data transfers, each closed by the external logic pulling an active-low ready line, then a single recovery cycle. Reads and writes share the same sequence. Requests of two to four words form a burst under one address cycle, with the low word-address bits stepping once per completed transfer.

The requester presents an address, a direction, a code/data flag, a transfer count and up to four words of write data, and the block takes them when it is idle or in recovery. The write/read and transceiver-direction outputs, the data/code outputs and the data bus are driven from the latched request. Read words come back one by one on a strobed output. After a write, the last word stays on the bus until the next address cycle begins, so the bus never floats between accesses.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is low and in the first cycle after reset, req_ready is 1, bus_as is 0, bus_doe is 0 and rd_valid is 0.
- R2: req_ready is 1 only in the idle and recovery states; a request with req_valid high while req_ready is high is taken at that clock edge, and in the next cycle bus_as is 1 for exactly one cycle with bus_addr equal to the request address; request inputs presented while req_ready is 0 have no effect.
- R3: In a data cycle, bus_rdy_n sampled high repeats the cycle as a wait state with the same address and write data; the transfer completes only when bus_rdy_n is sampled low; bus_rdy_n in the address cycle has no effect.
- R4: From the address cycle of an access onward, bus_wr and bus_dir are both 1 for a write and both 0 for a read.
- R5: bus_dc is 1 (data) for every write; for a read it is 1 when req_code was 0 and 0 when req_code was 1.
- R6: req_count holds the number of transfers minus one (0 = one transfer, 3 = four); the access performs exactly that many completed transfers and then enters recovery.
- R7: During transfer i (i = 0 first) bus_addr equals the request address with bits [3:2] replaced by (request bits [3:2] + i) mod 4; all other bits are unchanged.
- R8: During every data cycle of a write, bus_doe is 1 and bus_dout is word i of req_wdata, bits [32*i+31 : 32*i], for transfer i.
- R9: After a write, bus_doe stays 1 and bus_dout keeps the last word during recovery and all idle cycles that follow; bus_doe is 0 in every address cycle and during all cycles of a read access.
- R10: On a read, in the cycle after bus_rdy_n is sampled low in a data cycle, rd_valid is 1 for one cycle and rd_data equals the bus_din value sampled at that edge; rd_valid is 0 otherwise.
- R11: Recovery lasts exactly one cycle, with req_ready 1; it is followed by an address cycle if a request is accepted there, otherwise by idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | ADDR_W | Byte address of the first word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_code | input | 1 | 1 = instruction fetch (reads only) |
| req_count | input | CNT_W | Number of transfers minus one |
| req_wdata | input | MAX_XFER*DATA_W | Write words, word i in slice i |
| bus_addr | output | ADDR_W | Bus address, word bits stepping per transfer |
| bus_as | output | 1 | High during the address cycle |
| bus_wr | output | 1 | Write/read indicator, high for write |
| bus_dir | output | 1 | Transceiver direction, high for write |
| bus_dc | output | 1 | Data/code indicator, high for data |
| bus_dout | output | DATA_W | Write data to the bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Read data from the bus |
| bus_rdy_n | input | 1 | Active-low transfer ready |
| rd_valid | output | 1 | Read word strobe |
| rd_data | output | DATA_W | Captured read word |

## Verification
The address cycle is due one clock after the edge that takes a request, each data cycle's address and write data are due in that same cycle, the read strobe is due one clock after the edge where ready is low, and recovery is due one clock after the last ready. The bench drives inputs and samples outputs at the falling edge, advancing its expected state one clock per sample, so each check lands in the cycle where the result is due. Random wait counts, burst lengths, directions and back-to-back or idle gaps, together with junk on the request lines while the block is busy, exercise every transition, and expected values are built from the request the bench issued.

// File: rtl/bcs_pkg.sv
// Shared types for the bus cycle sequencer.
package bcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_REC  = 2'd3
    } bcs_state_e;
endpackage

// File: rtl/bcs_fsm.sv
// Access state machine: idle -> address -> data (repeats while not ready
// or transfers remain) -> one recovery cycle -> address or idle.
// Assumes xfer_done is only asserted in the data state.
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       xfer_done,
    input  logic       last_xfer,
    output logic       req_ready,
    output logic       req_fire,
    output bcs_state_e state_o
);
    bcs_state_e state_q, state_d;

    // Request acceptance window: idle or recovery only.
    always_comb begin
        req_ready = (state_q == ST_IDLE) || (state_q == ST_REC);
        req_fire  = req_valid && req_ready;
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_fire ? ST_ADDR : ST_IDLE;
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: state_d = (xfer_done && last_xfer) ? ST_REC : ST_DATA;
            ST_REC:  state_d = req_fire ? ST_ADDR : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/bcs_xfer_ctr.sv
// Transfer counter and address generator. Holds the request base address
// and count, steps the word index after each completed non-final transfer
// and forms the bus address with the word bits advanced by the index.
// Assumes MAX_XFER is a power of two and at least two.
module bcs_xfer_ctr #(
    parameter int ADDR_W  = 32,
    parameter int CNT_W   = 2,
    parameter int BYTE_SH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              advance,
    output logic [CNT_W-1:0]  idx_o,
    output logic              last_o,
    output logic [ADDR_W-1:0] bus_addr_o
);
    localparam int LO = BYTE_SH;
    localparam int HI = BYTE_SH + CNT_W;

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  count_q;
    logic [CNT_W-1:0]  idx_q;

    // Latch base and count on accept; step the index per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            count_q <= '0;
            idx_q   <= '0;
        end else if (load) begin
            base_q  <= base_i;
            count_q <= count_i;
            idx_q   <= '0;
        end else if (advance) begin
            idx_q   <= idx_q + 1'b1;
        end
    end

    // Final-transfer flag and stepped word address.
    always_comb begin
        last_o             = (idx_q == count_q);
        bus_addr_o         = base_q;
        bus_addr_o[HI-1:LO] = base_q[HI-1:LO] + idx_q;
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/bcs_datapath.sv
// Data path: latches direction, code flag and write words on accept,
// drives the selected write word (held after a write until the next
// address cycle), and captures read words when ready is sampled low.
module bcs_datapath
    import bcs_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int MAX_XFER = 4,
    parameter int CNT_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       write_i,
    input  logic                       code_i,
    input  logic [MAX_XFER*DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]           idx_i,
    input  bcs_state_e                 state_i,
    input  logic                       rdy_n_i,
    input  logic [DATA_W-1:0]          din_i,
    output logic                       write_o,
    output logic                       dc_o,
    output logic [DATA_W-1:0]          dout_o,
    output logic                       doe_o,
    output logic                       rd_valid_o,
    output logic [DATA_W-1:0]          rd_data_o
);
    logic                       write_q;
    logic                       code_q;
    logic [MAX_XFER*DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0]          words [MAX_XFER];

    // Latch the request attributes on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            write_q <= 1'b0;
            code_q  <= 1'b0;
            wdata_q <= '0;
        end else if (load) begin
            write_q <= write_i;
            code_q  <= code_i;
            wdata_q <= wdata_i;
        end
    end

    // Split the write block into words.
    for (genvar g = 0; g < MAX_XFER; g++) begin : g_word
        assign words[g] = wdata_q[g*DATA_W +: DATA_W];
    end

    // Bus drive: held after a write, released in the address cycle.
    always_comb begin
        write_o = write_q;
        dc_o    = write_q | ~code_q;
        dout_o  = words[idx_i];
        doe_o   = write_q && (state_i != ST_ADDR);
    end

    // Read capture on a ready-terminated read transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= (state_i == ST_DATA) && !write_q && !rdy_n_i;
            if ((state_i == ST_DATA) && !write_q && !rdy_n_i)
                rd_data_o <= din_i;
        end
    end
endmodule

// File: rtl/bus_cycle_seq.sv
// Processor bus cycle sequencer top. One request becomes one access: an
// address cycle, one to MAX_XFER ready-terminated transfers and a single
// recovery cycle. Assumes word-aligned requests that do not cross the
// MAX_XFER-word block; arbitration and byte enables live elsewhere.
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int MAX_XFER = 4,
    localparam int CNT_W   = $clog2(MAX_XFER),
    localparam int BYTE_SH = $clog2(DATA_W / 8)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_write,
    input  logic                       req_code,
    input  logic [CNT_W-1:0]           req_count,
    input  logic [MAX_XFER*DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0]          bus_addr,
    output logic                       bus_as,
    output logic                       bus_wr,
    output logic                       bus_dir,
    output logic                       bus_dc,
    output logic [DATA_W-1:0]          bus_dout,
    output logic                       bus_doe,
    input  logic [DATA_W-1:0]          bus_din,
    input  logic                       bus_rdy_n,
    output logic                       rd_valid,
    output logic [DATA_W-1:0]          rd_data
);
    bcs_state_e       state_q;
    logic             req_fire;
    logic             xfer_done;
    logic             last_xfer;
    logic             write_q;
    logic [CNT_W-1:0] idx;

    // Transfer completion: ready low in a data cycle.
    always_comb begin
        xfer_done = (state_q == ST_DATA) && !bus_rdy_n;
    end

    bcs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .xfer_done (xfer_done),
        .last_xfer (last_xfer),
        .req_ready (req_ready),
        .req_fire  (req_fire),
        .state_o   (state_q)
    );

    bcs_xfer_ctr #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .BYTE_SH (BYTE_SH)
    ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (req_fire),
        .base_i     (req_addr),
        .count_i    (req_count),
        .advance    (xfer_done && !last_xfer),
        .idx_o      (idx),
        .last_o     (last_xfer),
        .bus_addr_o (bus_addr)
    );

    bcs_datapath #(
        .DATA_W   (DATA_W),
        .MAX_XFER (MAX_XFER),
        .CNT_W    (CNT_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (req_fire),
        .write_i    (req_write),
        .code_i     (req_code),
        .wdata_i    (req_wdata),
        .idx_i      (idx),
        .state_i    (state_q),
        .rdy_n_i    (bus_rdy_n),
        .din_i      (bus_din),
        .write_o    (write_q),
        .dc_o       (bus_dc),
        .dout_o     (bus_dout),
        .doe_o      (bus_doe),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );

    // Direction indicators and address strobe.
    always_comb begin
        bus_wr  = write_q;
        bus_dir = write_q;
        bus_as  = (state_q == ST_ADDR);
    end
endmodule

// File: rtl/bcs_checker.sv
// Property checker for the bus cycle sequencer, bound to the top module.
module bcs_checker
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ready,
    input  logic              bus_as,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rdy_n,
    input  logic              bus_doe,
    input  logic [DATA_W-1:0] bus_dout,
    input  logic              bus_wr,
    input  logic              rd_valid,
    input  bcs_state_e        state
);
    AST_AS_SINGLE:    assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |=> !bus_as);                                                   // R2
    AST_ACCEPT_TO_AS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> bus_as);                                  // R2
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |-> !req_ready);                                                // R2
    AST_WAIT_HOLDS:   assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && bus_rdy_n) |=> (state == ST_DATA && $stable(bus_addr))); // R3
    AST_ADDR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as |-> !bus_doe);                                                  // R9
    AST_IDLE_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && bus_doe && !req_valid) |=> (bus_doe && $stable(bus_dout))); // R9
    AST_REC_ONCE:     assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REC) |=> (state != ST_REC));                              // R11
    AST_RDV_READ:     assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !bus_wr);                                                 // R10
    AST_RDV_CAUSE:    assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(state == ST_DATA && !bus_rdy_n));                   // R10
endmodule

bind bus_cycle_seq bcs_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_as    (bus_as),
    .bus_addr  (bus_addr),
    .bus_rdy_n (bus_rdy_n),
    .bus_doe   (bus_doe),
    .bus_dout  (bus_dout),
    .bus_wr    (bus_wr),
    .rd_valid  (rd_valid),
    .state     (state_q)
);

// File: tb/tb_bus_cycle_seq.sv
// Bench: directed corner cases plus seeded random accesses; inputs driven
// and outputs sampled at the falling edge.
module tb_bus_cycle_seq;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int MX = 4;
    localparam int CW = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           req_valid;
    logic           req_ready;
    logic [AW-1:0]  req_addr;
    logic           req_write;
    logic           req_code;
    logic [CW-1:0]  req_count;
    logic [MX*DW-1:0] req_wdata;
    logic [AW-1:0]  bus_addr;
    logic           bus_as, bus_wr, bus_dir, bus_dc, bus_doe;
    logic [DW-1:0]  bus_dout;
    logic [DW-1:0]  bus_din;
    logic           bus_rdy_n;
    logic           rd_valid;
    logic [DW-1:0]  rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic          last_wr   = 1'b0;
    logic [DW-1:0] last_word = '0;

    always #10 clk = ~clk;

    bus_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_code(req_code),
        .req_count(req_count), .req_wdata(req_wdata), .bus_addr(bus_addr),
        .bus_as(bus_as), .bus_wr(bus_wr), .bus_dir(bus_dir), .bus_dc(bus_dc),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_rdy_n(bus_rdy_n), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input int i);
        logic [AW-1:0] r;
        r = base;
        r[3:2] = base[3:2] + 2'(i);
        return r;
    endfunction

    function automatic logic exp_dc(input logic w, input logic c);
        return w | ~c;
    endfunction

    function automatic logic [AW-1:0] align(input logic [AW-1:0] a, input int n);
        if (n > 2)       return a & ~32'hF;
        else if (n == 2) return a & ~32'h7;
        else             return a & ~32'h3;
    endfunction

    // Run one access; entered just after a falling edge in idle or recovery,
    // returns at the falling edge inside the recovery cycle.
    task automatic access(input logic [AW-1:0] a, input logic w, input logic c,
                          input int n, input logic [MX*DW-1:0] wd, input int maxwait);
        logic          exp_rv;
        logic [DW-1:0] exp_rd;
        chk("R2 ready before accept", req_ready, 1'b1);
        req_valid = 1'b1; req_addr = a; req_write = w; req_code = c;
        req_count = CW'(n - 1); req_wdata = wd;
        bus_rdy_n = 1'($urandom_range(0, 1));
        @(negedge clk);
        chk("R2 address strobe", bus_as, 1'b1);
        chk("R2 address", bus_addr, a);
        chk("R2 not ready in address", req_ready, 1'b0);
        chk("R4 wr", bus_wr, w);
        chk("R4 dir", bus_dir, w);
        chk("R5 dc", bus_dc, exp_dc(w, c));
        chk("R9 released in address", bus_doe, 1'b0);
        chk("R10 no strobe in address", rd_valid, 1'b0);
        // junk on the request lines while busy: must be ignored (R2)
        req_valid = 1'($urandom_range(0, 1)); req_addr = $urandom;
        req_write = 1'($urandom_range(0, 1)); req_code = 1'($urandom_range(0, 1));
        req_count = CW'($urandom_range(0, 3));
        exp_rv = 1'b0; exp_rd = '0;
        for (int i = 0; i < n; i++) begin
            int waits;
            waits = (maxwait > 0) ? $urandom_range(0, maxwait) : 0;
            for (int k = 0; k <= waits; k++) begin
                @(negedge clk) ;
                chk("R10 read strobe", rd_valid, exp_rv);
                if (exp_rv) chk("R10 read data", rd_data, exp_rd);
                chk("R2 no strobe in data", bus_as, 1'b0);
                chk("R2 not ready in data", req_ready, 1'b0);
                chk((k > 0) ? "R3 address held in wait" : "R7 stepped address",
                    bus_addr, exp_addr(a, i));
                chk("R4 wr in data", bus_wr, w);
                if (w) begin
                    chk("R8 drive enable", bus_doe, 1'b1);
                    chk((k > 0) ? "R3 data held in wait" : "R8 write word",
                        bus_dout, wd[i*DW +: DW]);
                end else begin
                    chk("R9 no drive on read", bus_doe, 1'b0);
                end
                bus_rdy_n = (k < waits);
                bus_din   = $urandom;
                exp_rv    = !w && (k == waits);
                exp_rd    = bus_din;
                // step back so the next loop edge lands on the next cycle
                @(posedge clk);
            end
        end
        @(negedge clk);
        chk("R10 last read strobe", rd_valid, exp_rv);
        if (exp_rv) chk("R10 last read data", rd_data, exp_rd);
        chk("R6 count done, ready in recovery", req_ready, 1'b1);
        chk("R11 recovery no strobe", bus_as, 1'b0);
        chk("R9 drive in recovery", bus_doe, w);
        if (w) chk("R9 word held in recovery", bus_dout, wd[(n-1)*DW +: DW]);
        req_valid = 1'b0;
        bus_rdy_n = 1'($urandom_range(0, 1));
        last_wr   = w;
        last_word = wd[(n-1)*DW +: DW];
    endtask

    // One idle cycle after recovery or idle with no request.
    task automatic idle_cycle();
        @(negedge clk);
        chk("R11 idle ready", req_ready, 1'b1);
        chk("R11 idle no strobe", bus_as, 1'b0);
        chk("R9 drive held in idle", bus_doe, last_wr);
        if (last_wr) chk("R9 word held in idle", bus_dout, last_word);
        chk("R10 no strobe in idle", rd_valid, 1'b0);
    endtask

    function automatic logic [MX*DW-1:0] rand_block();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Main stimulus.
    initial begin
        int seed;
        seed = $urandom(32'd7731);
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
        req_code = 1'b0; req_count = '0; req_wdata = '0; bus_din = '0; bus_rdy_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", req_ready, 1'b1);
        chk("R1 reset strobe", bus_as, 1'b0);
        chk("R1 reset drive", bus_doe, 1'b0);
        chk("R1 reset read strobe", rd_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle ready", req_ready, 1'b1);
        chk("R1 first cycle drive", bus_doe, 1'b0);

        // single read, no waits
        access(32'h1000_0004, 1'b0, 1'b0, 1, '0, 0);
        idle_cycle();
        // single write with waits, then a long idle hold
        access(32'h2000_0018, 1'b1, 1'b0, 1, rand_block(), 3);
        repeat (3) idle_cycle();
        // four-word write burst
        access(32'h3000_0020, 1'b1, 1'b0, 4, rand_block(), 2);
        repeat (2) idle_cycle();
        // code fetch burst of two, then back-to-back write and read
        access(32'h4000_0048, 1'b0, 1'b1, 2, '0, 2);
        access(32'h5000_0030, 1'b1, 1'b0, 3, rand_block(), 1);
        access(32'h6000_0040, 1'b0, 1'b0, 4, '0, 0);
        idle_cycle();
        // word bits wrap within the four-word block
        access(32'h7000_000C, 1'b0, 1'b0, 4, '0, 1);
        idle_cycle();

        // seeded random mix
        for (int t = 0; t < 80; t++) begin
            int n;
            int gap;
            n = $urandom_range(1, 4);
            access(align($urandom, n), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                   n, rand_block(), 3);
            gap = $urandom_range(0, 2);
            for (int g = 0; g < gap; g++) idle_cycle();
        end
        idle_cycle();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule